// File: doc/BRIEF.md
# Self-Synchronizing Bit Scrambler and Descrambler

This block whitens a serial bit stream so that long runs of equal bits do not reach the line. It can also undo that whitening at the far end. Each bit is combined by XOR with two earlier bits, taken from a 23-deep history, at delays of 18 and 23 valid bits. The mode input picks which bits enter the history.

In scramble mode, the history holds the block's own output bits. In descramble mode, it holds the received input bits. Because of this, a descrambler that starts from the wrong state, or that sees a corrupted bit, locks back onto the stream without help. It does so once 23 clean bits have passed through it.

The history starts at zero after reset. A synchronous clear also returns it to zero. The history moves only on cycles that carry a valid bit. Each result appears one cycle after its input, with its own valid flag.

Top module: `scr_selfsync`

## Requirements
- R1: After reset, out_vld_o and out_bit_o are 0 and the history is all zeros.
- R2: With mode_i = 0 (scramble), each valid output equals the input bit XOR the outputs produced 18 and 23 valid bits earlier. Earlier bits that do not exist count as 0.
- R3: With mode_i = 1 (descramble), each valid output equals the input bit XOR the inputs received 18 and 23 valid bits earlier. Earlier bits that do not exist count as 0.
- R4: mode_i is sampled with every valid bit, so the mode can change from one bit to the next. The history is shared by both modes.
- R5: out_vld_o is in_vld_o's value of the previous cycle, and out_bit_o carries the result for that bit. Latency is one cycle.
- R6: On a cycle with in_vld_i = 0, the history does not change, and out_bit_o keeps its last value one cycle later.
- R7: With clr_i = 1, the history is zero on the next cycle and out_vld_o is 0 on the next cycle. A bit presented in the same cycle is discarded.
- R8: Scrambling a stream from a zero history and then descrambling the result from a zero history returns the original stream.
- R9: A single flipped bit at position p of a descrambled stream corrupts exactly the outputs at p, p+18 and p+23.
- R10: With an all-zero history, an all-zero input stream yields an all-zero output in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the history |
| mode_i | input | 1 | 0 = scramble, 1 = descramble |
| in_bit_i | input | 1 | Serial data in |
| in_vld_i | input | 1 | Input bit qualifier |
| out_bit_o | output | 1 | Serial data out |
| out_vld_o | output | 1 | Output bit qualifier |

## Verification
The bench builds the block with its default parameters: a 23-deep history with a near tap at 18. Streams of 200 bits therefore reach the delay-23 term many times, and the error test can reach the third corrupted position at p+23. A flipped bit at position 50 lands its echoes at 68 and 73, which are well inside the stream, so the resynchronization after them is visible too. The bench also switches the mode bit by bit over a shared history and inserts valid gaps in the middle of the stream.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic {
        SCR_MODE_SCRAMBLE   = 1'b0,
        SCR_MODE_DESCRAMBLE = 1'b1
    } scr_mode_e;

    typedef struct packed {
        logic bit_v;
        logic vld;
    } scr_out_t;

endpackage

// File: rtl/scr_history.sv
// Bit history: index 0 holds the most recent bit (delay 1).
module scr_history #(
    parameter int LEN = 23
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           clr_i,
    input  logic           adv_i,
    input  logic           din_i,
    output logic [LEN-1:0] hist_o
);

    logic [LEN-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (clr_i) begin
            hist_d = '0;
        end else if (adv_i) begin
            hist_d = {hist_q[LEN-2:0], din_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/scr_taps.sv
// Sum of the two taps: delays TAP_NEAR and LEN.
module scr_taps #(
    parameter int LEN      = 23,
    parameter int TAP_NEAR = 18
) (
    input  logic [LEN-1:0] hist_i,
    output logic           fb_o
);

    localparam int IDX_NEAR = TAP_NEAR - 1;
    localparam int IDX_FAR  = LEN - 1;

    generate
        if (TAP_NEAR >= 1 && TAP_NEAR < LEN) begin : g_two_tap
            assign fb_o = hist_i[IDX_NEAR] ^ hist_i[IDX_FAR];
        end else begin : g_far_only
            assign fb_o = hist_i[IDX_FAR];
        end
    endgenerate

endmodule

// File: rtl/scr_selfsync.sv
module scr_selfsync #(
    parameter int SR_LEN   = 23,
    parameter int TAP_NEAR = 18
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic mode_i,
    input  logic in_bit_i,
    input  logic in_vld_i,
    output logic out_bit_o,
    output logic out_vld_o
);

    import scr_pkg::*;

    logic [SR_LEN-1:0] hist_q;
    logic              fb;
    logic              mix;
    logic              shift_bit;
    logic              adv;
    scr_mode_e         mode;
    scr_out_t          out_d, out_q;

    assign mode = scr_mode_e'(mode_i);
    assign adv  = in_vld_i && !clr_i;

    scr_taps #(
        .LEN      (SR_LEN),
        .TAP_NEAR (TAP_NEAR)
    ) u_taps (
        .hist_i (hist_q),
        .fb_o   (fb)
    );

    always_comb begin
        mix       = in_bit_i ^ fb;
        shift_bit = (mode == SCR_MODE_DESCRAMBLE) ? in_bit_i : mix;
        out_d     = out_q;
        out_d.vld = adv;
        if (adv) begin
            out_d.bit_v = mix;
        end
    end

    scr_history #(
        .LEN (SR_LEN)
    ) u_hist (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_i),
        .adv_i  (adv),
        .din_i  (shift_bit),
        .hist_o (hist_q)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_bit_o = out_q.bit_v;
    assign out_vld_o = out_q.vld;

endmodule

// File: rtl/scr_selfsync_chk.sv
module scr_selfsync_chk #(
    parameter int LEN = 23
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           clr_i,
    input logic           mode_i,
    input logic           in_bit_i,
    input logic           in_vld_i,
    input logic           out_bit_o,
    input logic           out_vld_o,
    input logic [LEN-1:0] hist_i
);

    AST_VLD_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_vld_i && !clr_i) |=> out_vld_o); // R5

    AST_NO_VLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_vld_i |=> !out_vld_o); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_vld_i && !clr_i) |=> ($stable(hist_i) && $stable(out_bit_o))); // R6

    AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (hist_i == '0 && !out_vld_o)); // R7

    AST_SCR_FEEDS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_vld_i && !clr_i && !mode_i) |=> (hist_i[0] == out_bit_o)); // R2

    AST_DSC_FEEDS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_vld_i && !clr_i && mode_i) |=> (hist_i[0] == $past(in_bit_i))); // R3

    AST_ZERO_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hist_i == '0 && in_vld_i && !clr_i && !in_bit_i) |=> !out_bit_o); // R10

endmodule

bind scr_selfsync scr_selfsync_chk #(.LEN(SR_LEN)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .mode_i    (mode_i),
    .in_bit_i  (in_bit_i),
    .in_vld_i  (in_vld_i),
    .out_bit_o (out_bit_o),
    .out_vld_o (out_vld_o),
    .hist_i    (hist_q)
);

// File: tb/tb_scr_selfsync.sv
module tb_scr_selfsync;

    localparam int NBITS = 200;
    localparam int ERR_POS = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic mode = 1'b0;
    logic in_bit = 1'b0;
    logic in_vld = 1'b0;
    logic out_bit;
    logic out_vld;

    always #2.5 clk = ~clk;

    scr_selfsync dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .clr_i     (clr),
        .mode_i    (mode),
        .in_bit_i  (in_bit),
        .in_vld_i  (in_vld),
        .out_bit_o (out_bit),
        .out_vld_o (out_vld)
    );

    int nchk = 0;
    int nfail = 0;
    bit exp_q[$];
    string tag_q[$];
    bit got_q[$];
    bit capture = 1'b0;
    logic [22:0] m = '0;
    bit orig[NBITS];
    bit scr[NBITS];
    logic [15:0] prng = 16'hACE1;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected valid", 1, 0);
            end else begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_bit == e, t, out_bit, e);
                if (capture) got_q.push_back(out_bit);
            end
        end
    end

    function automatic bit next_rand();
        prng = {prng[14:0], prng[15] ^ prng[13] ^ prng[12] ^ prng[10]};
        return prng[0];
    endfunction

    // driver with independent model of the polynomial
    task automatic push_bit(input bit md, input bit d, input bit exp_override,
                            input bit use_override, input string tag, output bit res);
        bit o;
        @(negedge clk);
        mode = md;
        in_bit = d;
        in_vld = 1'b1;
        o = d ^ m[17] ^ m[22];
        m = {m[21:0], md ? d : o};
        res = o;
        exp_q.push_back(use_override ? exp_override : o);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        in_vld = 1'b1;
        in_bit = 1'b1;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        in_vld = 1'b0;
        m = '0;
        check(out_vld == 1'b0, "R7 valid after clear", out_vld, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        bit r;
        repeat (3) @(negedge clk);
        check(out_vld == 1'b0, "R1 out_vld", out_vld, 0);
        check(out_bit == 1'b0, "R1 out_bit", out_bit, 0);
        rst_n = 1'b1;

        // R10 zeros in both modes
        for (int i = 0; i < 30; i++) push_bit(i[0], 1'b0, 1'b0, 1'b1, "R10", r);
        idle(2);

        // R2 impulse response from zero state
        push_bit(1'b0, 1'b1, 1'b0, 1'b0, "R2 impulse", r);
        for (int i = 0; i < 60; i++) push_bit(1'b0, 1'b0, 1'b0, 1'b0, "R2 impulse", r);
        idle(2);

        // R7 clear from nonzero history, then impulse must restart clean
        do_clear();
        push_bit(1'b0, 1'b1, 1'b1, 1'b1, "R7 first", r);
        for (int i = 1; i < 30; i++)
            push_bit(1'b0, 1'b0, (i == 18 || i == 23), 1'b1, "R7 after clear", r);
        idle(2);

        // R2 pseudo-random scramble with gaps (R6)
        do_clear();
        for (int i = 0; i < NBITS; i++) begin
            orig[i] = next_rand();
            push_bit(1'b0, orig[i], 1'b0, 1'b0, "R2 random", r);
            scr[i] = r;
            if (i == 70 || i == 140) begin
                bit held;
                @(negedge clk);
                in_vld = 1'b0;
                @(negedge clk);
                held = out_bit;
                repeat (4) begin
                    @(negedge clk);
                    check(out_vld == 1'b0 && out_bit == held, "R6 idle hold",
                          {out_vld, out_bit}, {1'b0, held});
                end
            end
        end
        idle(2);

        // R8 / R3 round trip
        do_clear();
        for (int i = 0; i < NBITS; i++) push_bit(1'b1, scr[i], orig[i], 1'b1, "R8 round trip", r);
        idle(2);

        // R9 single error, R3 model per bit
        do_clear();
        capture = 1'b1;
        got_q.delete();
        for (int i = 0; i < NBITS; i++)
            push_bit(1'b1, scr[i] ^ (i == ERR_POS), 1'b0, 1'b0, "R3 corrupted stream", r);
        idle(2);
        capture = 1'b0;
        begin
            int nerr = 0;
            bit pos_ok = 1'b1;
            for (int i = 0; i < got_q.size(); i++) begin
                if (got_q[i] != orig[i]) begin
                    nerr++;
                    if (!(i == ERR_POS || i == ERR_POS + 18 || i == ERR_POS + 23)) pos_ok = 1'b0;
                end
            end
            check(got_q.size() == NBITS, "R9 length", got_q.size(), NBITS);
            check(nerr == 3, "R9 error count", nerr, 3);
            check(pos_ok, "R9 error positions", pos_ok, 1);
        end

        // R4 mode changing bit by bit over a shared history
        do_clear();
        for (int i = 0; i < 80; i++) push_bit(i[2], next_rand(), 1'b0, 1'b0, "R4 mixed mode", r);
        idle(3);

        check(exp_q.size() == 0, "R5 outstanding items", exp_q.size(), 0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule